// File: doc/BRIEF.md
# Clock Fanout Buffer Control Core

This block is the digital controller of a four-lane differential clock fanout buffer. Two strap inputs arrive already resolved from their three-level receivers into a low, mid or high code. One strap selects the serial-bus device address and the other selects the PLL operating mode. The controller captures both straps once, on the first rising of the power-good input. After that the same input works as a power-down request: low parks the device and high resumes it. The captured straps are kept until a full reset.

Each output lane is enabled only when all of the following agree: the power state, the reference-clock-present flag, the PLL lock flag, a software enable bit and an active-low enable pin. The lock flag is skipped when the effective mode is bypass. The enable pins and the status flags are asynchronous, so each passes through a two-flop synchroniser. The per-lane gate is updated on the falling clock edge, which means a lane starts or stops only while the clock is low. A small register file holds the enable bits, a mode override and the input-frequency field. The block presents the latched address, the effective PLL mode, a PLL-enable output and the readback fields to the serial bus engine.

Top module: `clkbuf_ctrl`

## Requirements
- R1: The straps are captured only when power-good first goes high after reset. Later strap changes and power-down cycles leave `bus_addr` and `strap_mode_rb` unchanged until the next reset.
- R2: Address strap code 2'b00 gives address 7'b1101011, 2'b10 gives 7'b1101101, and any other code (mid) gives 7'b1101100.
- R3: Once started, power-good low drives every lane low on both sides and drives `pll_on` low. Power-good high again resumes the lanes without capturing the straps again.
- R4: Mode strap 2'b00 selects low bandwidth (code 2'b00), 2'b10 selects high bandwidth (2'b11), and any other code selects bypass (2'b01). `strap_mode_rb` reports that captured code.
- R5: When the stored override-enable bit is 1, `pll_mode` takes the stored override code. A write that carries override code 2'b10 keeps the previously stored override code. The override-enable bit resets to 0.
- R6: Lane i runs only when all four of these hold: the device is powered, `ref_running` is 1, enable bit i is 1 and `oe_n[i]` is 0. Otherwise both of its sides are low.
- R7: While the effective mode is not bypass, every lane is held low until `pll_lock` is 1. In bypass, lanes run without lock and `pll_on` is 0.
- R8: The frequency field resets to 2'b00. `ref_mhz` reports 100 for 2'b00, 50 for 2'b01, 125 for 2'b10 and 0 (reserved) for 2'b11. It is read back on `fsel_rb`.
- R9: The per-lane enable bits reset to all ones and are read back on `oe_rb`, so the pins alone control the lanes.
- R10: A lane's gate changes only on a falling clock edge, so the first true-side pulse after enabling lasts a full half period.
- R11: A running lane drives `dif_t` equal to the clock and `dif_c` equal to its inverse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fanout clock, also the control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrgd | input | 1 | Power-good / power-down request |
| addr_strap | input | 2 | Resolved address strap (00 low, 01 mid, 10 high) |
| mode_strap | input | 2 | Resolved PLL mode strap (00 low, 01 mid, 10 high) |
| ref_running | input | 1 | Input reference clock present |
| pll_lock | input | 1 | PLL lock indication |
| oe_n | input | 4 | Active-low per-lane enable pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_oe | input | 4 | Written per-lane enable bits |
| cfg_ovr_en | input | 1 | Written override-enable bit |
| cfg_ovr_mode | input | 2 | Written override mode code |
| cfg_fsel | input | 2 | Written frequency field |
| bus_addr | output | 7 | Latched serial-bus address |
| strap_mode_rb | output | 2 | Mode captured from the strap |
| pll_mode | output | 2 | Effective PLL mode |
| pll_on | output | 1 | PLL enable |
| ref_mhz | output | 8 | Input frequency in MHz, 0 when reserved |
| oe_rb | output | 4 | Enable bit readback |
| fsel_rb | output | 2 | Frequency field readback |
| dif_t | output | 4 | True side of each lane |
| dif_c | output | 4 | Complement side of each lane |

## Verification
The hardest state to reach is a later power-good rising edge after the straps have moved, because that edge has to resume the lanes without capturing the straps again. The stimulus changes both straps while the device is powered down. It then raises power-good and checks that the address and the mode readback still hold the first captured values, and that the lanes come back. A second hard case is bypass with the lock flag low. The stimulus drops lock and then writes a bypass override, and the lanes are expected to run again while `pll_on` stays low.

// File: rtl/clkbuf_pkg.sv
package clkbuf_pkg;

  localparam logic [1:0] TRI_LOW  = 2'b00;
  localparam logic [1:0] TRI_HIGH = 2'b10;

  typedef enum logic [1:0] {
    MODE_LOBW   = 2'b00,
    MODE_BYPASS = 2'b01,
    MODE_HIBW   = 2'b11
  } pll_mode_e;

  typedef enum logic [1:0] {
    PWR_WAIT = 2'b00,
    PWR_ON   = 2'b01,
    PWR_DOWN = 2'b10
  } pwr_state_e;

  function automatic pll_mode_e mode_from_strap(input logic [1:0] s);
    case (s)
      TRI_LOW:  return MODE_LOBW;
      TRI_HIGH: return MODE_HIBW;
      default:  return MODE_BYPASS;
    endcase
  endfunction

  function automatic logic mode_code_ok(input logic [1:0] c);
    return c != 2'b10;
  endfunction

  function automatic logic [7:0] freq_mhz(input logic [1:0] f);
    case (f)
      2'b00:   return 8'd100;
      2'b01:   return 8'd50;
      2'b10:   return 8'd125;
      default: return 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/clkbuf_sync.sv
module clkbuf_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) pipe_q[s] <= RST_VAL;
    end else begin
      pipe_q[0] <= d;
      for (int s = 1; s < int'(STAGES); s++) pipe_q[s] <= pipe_q[s-1];
    end
  end

  assign q = pipe_q[STAGES-1];

endmodule

// File: rtl/clkbuf_pwr.sv
module clkbuf_pwr
  import clkbuf_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter logic [ADDR_W-1:0] ADDR_LO  = 7'b1101011,
  parameter logic [ADDR_W-1:0] ADDR_MID = 7'b1101100,
  parameter logic [ADDR_W-1:0] ADDR_HI  = 7'b1101101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pg_s,
  input  logic [1:0]        addr_strap,
  input  logic [1:0]        mode_strap,
  output logic              pwr_on,
  output logic [ADDR_W-1:0] bus_addr,
  output pll_mode_e         strap_mode
);

  pwr_state_e        state_q, state_d;
  logic              latch_en;
  logic [ADDR_W-1:0] addr_q, addr_dec;
  pll_mode_e         mode_q;

  always_comb begin
    case (addr_strap)
      TRI_LOW:  addr_dec = ADDR_LO;
      TRI_HIGH: addr_dec = ADDR_HI;
      default:  addr_dec = ADDR_MID;
    endcase
  end

  assign latch_en = (state_q == PWR_WAIT) && pg_s;

  always_comb begin
    state_d = state_q;
    case (state_q)
      PWR_WAIT: if (pg_s)  state_d = PWR_ON;
      PWR_ON:   if (!pg_s) state_d = PWR_DOWN;
      PWR_DOWN: if (pg_s)  state_d = PWR_ON;
      default:             state_d = PWR_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PWR_WAIT;
      addr_q  <= ADDR_LO;
      mode_q  <= MODE_LOBW;
    end else begin
      state_q <= state_d;
      if (latch_en) begin
        addr_q <= addr_dec;
        mode_q <= mode_from_strap(mode_strap);
      end
    end
  end

  assign pwr_on     = (state_q == PWR_ON);
  assign bus_addr   = addr_q;
  assign strap_mode = mode_q;

  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != PWR_WAIT) |=> ($stable(bus_addr) && $stable(strap_mode))); // R1
  AST_ADDR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_LO) || (bus_addr == ADDR_MID) || (bus_addr == ADDR_HI)); // R2
  AST_DOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !pg_s |=> !pwr_on); // R3

endmodule

// File: rtl/clkbuf_cfg.sv
module clkbuf_cfg
  import clkbuf_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [LANES-1:0] oe_wr,
  input  logic             ovr_en_wr,
  input  logic [1:0]       ovr_mode_wr,
  input  logic [1:0]       fsel_wr,
  output logic [LANES-1:0] oe_reg,
  output logic             ovr_en,
  output pll_mode_e        ovr_mode,
  output logic [1:0]       fsel
);

  logic mode_we;

  assign mode_we = we && mode_code_ok(ovr_mode_wr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_reg   <= '1;
      ovr_en   <= 1'b0;
      ovr_mode <= MODE_LOBW;
      fsel     <= 2'b00;
    end else begin
      if (we) begin
        oe_reg <= oe_wr;
        ovr_en <= ovr_en_wr;
        fsel   <= fsel_wr;
      end
      if (mode_we) ovr_mode <= pll_mode_e'(ovr_mode_wr);
    end
  end

  AST_OVR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode_code_ok(ovr_mode)); // R5
  AST_OVR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (ovr_mode_wr == 2'b10)) |=> $stable(ovr_mode)); // R5

endmodule

// File: rtl/clkbuf_gate.sv
module clkbuf_gate #(
  parameter int unsigned LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_on,
  input  logic             ref_ok,
  input  logic             lock_ok,
  input  logic             bypass,
  input  logic [LANES-1:0] oe_reg,
  input  logic [LANES-1:0] oe_n_s,
  output logic [LANES-1:0] gate
);

  logic common_ok;

  assign common_ok = pwr_on && ref_ok && (bypass || lock_ok);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic run_d;
    assign run_d = common_ok && oe_reg[i] && !oe_n_s[i];
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) gate[i] <= 1'b0;
      else        gate[i] <= run_d;
    end
  end

  AST_PWR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_on |-> (gate == '0)); // R3
  AST_REF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_ok |-> (gate == '0)); // R6
  AST_LOCK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && !lock_ok) |-> (gate == '0)); // R7

endmodule

// File: rtl/clkbuf_ctrl.sv
module clkbuf_ctrl
  import clkbuf_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwrgd,
  input  logic [1:0]        addr_strap,
  input  logic [1:0]        mode_strap,
  input  logic              ref_running,
  input  logic              pll_lock,
  input  logic [LANES-1:0]  oe_n,
  input  logic              cfg_we,
  input  logic [LANES-1:0]  cfg_oe,
  input  logic              cfg_ovr_en,
  input  logic [1:0]        cfg_ovr_mode,
  input  logic [1:0]        cfg_fsel,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        strap_mode_rb,
  output logic [1:0]        pll_mode,
  output logic              pll_on,
  output logic [7:0]        ref_mhz,
  output logic [LANES-1:0]  oe_rb,
  output logic [1:0]        fsel_rb,
  output logic [LANES-1:0]  dif_t,
  output logic [LANES-1:0]  dif_c
);

  localparam int unsigned FLAG_W = 3;

  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic [FLAG_W-1:0] flags_s;
  logic [LANES-1:0]  oe_n_s;
  logic              pwr_on;
  pll_mode_e         strap_mode, ovr_mode, mode_eff;
  logic              ovr_en, bypass;
  logic [LANES-1:0]  oe_reg, gate;
  logic [1:0]        fsel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  clkbuf_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_flag_sync (
    .clk(clk), .rst_n(rst_sync_n),
    .d({pwrgd, ref_running, pll_lock}), .q(flags_s)
  );

  clkbuf_sync #(.W(LANES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_oe_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(oe_n), .q(oe_n_s)
  );

  clkbuf_pwr #(.ADDR_W(ADDR_W)) u_pwr (
    .clk(clk), .rst_n(rst_sync_n), .pg_s(flags_s[2]),
    .addr_strap(addr_strap), .mode_strap(mode_strap),
    .pwr_on(pwr_on), .bus_addr(bus_addr), .strap_mode(strap_mode)
  );

  clkbuf_cfg #(.LANES(LANES)) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .we(cfg_we),
    .oe_wr(cfg_oe), .ovr_en_wr(cfg_ovr_en), .ovr_mode_wr(cfg_ovr_mode),
    .fsel_wr(cfg_fsel), .oe_reg(oe_reg), .ovr_en(ovr_en),
    .ovr_mode(ovr_mode), .fsel(fsel)
  );

  assign mode_eff = ovr_en ? ovr_mode : strap_mode;
  assign bypass   = (mode_eff == MODE_BYPASS);

  clkbuf_gate #(.LANES(LANES)) u_gate (
    .clk(clk), .rst_n(rst_sync_n), .pwr_on(pwr_on),
    .ref_ok(flags_s[1]), .lock_ok(flags_s[0]), .bypass(bypass),
    .oe_reg(oe_reg), .oe_n_s(oe_n_s), .gate(gate)
  );

  assign strap_mode_rb = strap_mode;
  assign pll_mode      = mode_eff;
  assign pll_on        = pwr_on && !bypass;
  assign ref_mhz       = freq_mhz(fsel);
  assign oe_rb         = oe_reg;
  assign fsel_rb       = fsel;
  assign dif_t         = gate & {LANES{clk}};
  assign dif_c         = gate & {LANES{~clk}};

  AST_PLL_OFF_BYP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (pll_mode == MODE_BYPASS) |-> !pll_on); // R7
  AST_PLL_OFF_DOWN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !pwr_on |-> !pll_on); // R3

endmodule

// File: tb/test_clkbuf_ctrl.sv
`timescale 1ns/1ps
module test_clkbuf_ctrl;

  typedef struct {
    string      req;
    int         sel;
    logic [7:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n, pwrgd, ref_running, pll_lock, cfg_we, cfg_ovr_en, pll_on;
  logic [1:0] addr_strap, mode_strap, cfg_ovr_mode, cfg_fsel;
  logic [1:0] strap_mode_rb, pll_mode, fsel_rb;
  logic [3:0] oe_n, cfg_oe, oe_rb, dif_t, dif_c;
  logic [6:0] bus_addr;
  logic [7:0] ref_mhz;

  item_t q[$];
  int n_cmp = 0;
  int n_bad = 0;

  bit m_pwr, m_ref, m_lock, m_byp;
  logic [3:0] m_oen, m_oereg;

  always #2 clk = ~clk;

  clkbuf_ctrl i_clkbuf_ctrl (
    .clk(clk), .rst_n(rst_n), .pwrgd(pwrgd), .addr_strap(addr_strap),
    .mode_strap(mode_strap), .ref_running(ref_running), .pll_lock(pll_lock),
    .oe_n(oe_n), .cfg_we(cfg_we), .cfg_oe(cfg_oe), .cfg_ovr_en(cfg_ovr_en),
    .cfg_ovr_mode(cfg_ovr_mode), .cfg_fsel(cfg_fsel), .bus_addr(bus_addr),
    .strap_mode_rb(strap_mode_rb), .pll_mode(pll_mode), .pll_on(pll_on),
    .ref_mhz(ref_mhz), .oe_rb(oe_rb), .fsel_rb(fsel_rb),
    .dif_t(dif_t), .dif_c(dif_c)
  );

  function automatic logic [3:0] exp_dif();
    logic [3:0] r;
    for (int i = 0; i < 4; i++)
      r[i] = m_pwr && m_ref && m_oereg[i] && !m_oen[i] && (m_byp || m_lock);
    return r;
  endfunction

  function automatic logic [7:0] observe(int sel);
    case (sel)
      0: return {4'h0, dif_t};
      2: return {1'b0, bus_addr};
      3: return {6'h0, strap_mode_rb};
      4: return {6'h0, pll_mode};
      5: return {7'h0, pll_on};
      6: return ref_mhz;
      7: return {4'h0, oe_rb};
      default: return {6'h0, fsel_rb};
    endcase
  endfunction

  // monitor: pops expected items and compares them to the outputs
  initial begin
    forever begin
      @(posedge clk);
      #1.5;
      while (q.size() != 0) begin
        item_t it;
        logic [7:0] got;
        bit bad;
        it = q[0];
        if (it.sel == 1) begin
          bad = (dif_c != 4'h0);
          got = {4'h0, dif_c};
          #2;
          if (!bad) got = {4'h0, dif_c};
          bad = bad || (dif_c != it.exp[3:0]);
        end else begin
          got = observe(it.sel);
          bad = (got != it.exp);
        end
        n_cmp++;
        if (bad) begin
          n_bad++;
          $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, got, it.exp);
        end
        void'(q.pop_front());
      end
    end
  end

  task automatic push(string req, int sel, logic [7:0] exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic settle();
    repeat (8) @(posedge clk);
    #1;
  endtask

  task automatic push_dif(string req);
    push(req, 0, {4'h0, exp_dif()});
    push(req, 1, {4'h0, exp_dif()});
  endtask

  task automatic cfg_write(logic [3:0] oe, logic en, logic [1:0] md, logic [1:0] fs);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_oe = oe; cfg_ovr_en = en; cfg_ovr_mode = md; cfg_fsel = fs;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    real t0;
    rst_n = 1'b0; pwrgd = 1'b0; addr_strap = 2'b10; mode_strap = 2'b10;
    ref_running = 1'b1; pll_lock = 1'b0; oe_n = 4'h0;
    cfg_we = 1'b0; cfg_oe = 4'h0; cfg_ovr_en = 1'b0; cfg_ovr_mode = 2'b00; cfg_fsel = 2'b00;
    m_pwr = 0; m_ref = 1; m_lock = 0; m_byp = 0; m_oen = 4'h0; m_oereg = 4'hF;
    repeat (4) @(posedge clk); #1;
    rst_n = 1'b1;
    settle();
    // reset state
    push("R9", 7, 8'h0F);
    push("R8", 6, 8'd100);
    push("R8", 8, 8'h00);
    push("R3", 5, 8'h00);
    push_dif("R6");
    drain();
    // first power-good: straps captured
    pwrgd = 1'b1; m_pwr = 1;
    settle();
    push("R2", 2, 8'h6D);
    push("R4", 3, 8'h03);
    push("R4", 4, 8'h03);
    push("R7", 5, 8'h01);
    push_dif("R7");
    drain();
    // lock: all lanes run, complement checked (R11)
    pll_lock = 1'b1; m_lock = 1;
    settle();
    push_dif("R11");
    drain();
    oe_n = 4'b0101; m_oen = 4'b0101;
    settle();
    push_dif("R6");
    drain();
    cfg_write(4'b0011, 1'b0, 2'b00, 2'b00); m_oereg = 4'b0011;
    settle();
    push("R9", 7, 8'h03);
    push_dif("R6");
    drain();
    cfg_write(4'hF, 1'b0, 2'b00, 2'b00); m_oereg = 4'hF;
    oe_n = 4'b0100; m_oen = 4'b0100;
    settle();
    // R10: first pulse after enabling lane 2 spans a half period
    oe_n = 4'b0000; m_oen = 4'b0000;
    @(posedge dif_t[2]); t0 = $realtime;
    @(negedge dif_t[2]);
    n_cmp++;
    if (($realtime - t0) < 1.99 || ($realtime - t0) > 2.01) begin
      n_bad++;
      $display("FAIL R10 pulse width actual=%0f expected=2.0", $realtime - t0);
    end
    settle();
    // power-down with straps moved
    addr_strap = 2'b00; mode_strap = 2'b00;
    pwrgd = 1'b0; m_pwr = 0;
    settle();
    push_dif("R3");
    push("R3", 5, 8'h00);
    push("R1", 2, 8'h6D);
    drain();
    pwrgd = 1'b1; m_pwr = 1;
    settle();
    push("R1", 2, 8'h6D);
    push("R1", 3, 8'h03);
    push_dif("R3");
    drain();
    ref_running = 1'b0; m_ref = 0;
    settle();
    push_dif("R6");
    drain();
    ref_running = 1'b1; m_ref = 1;
    pll_lock = 1'b0; m_lock = 0;
    settle();
    push_dif("R7");
    drain();
    cfg_write(4'hF, 1'b1, 2'b01, 2'b00); m_byp = 1;
    settle();
    push("R5", 4, 8'h01);
    push("R7", 5, 8'h00);
    push("R4", 3, 8'h03);
    push_dif("R7");
    drain();
    cfg_write(4'hF, 1'b1, 2'b10, 2'b00);
    settle();
    push("R5", 4, 8'h01);
    push_dif("R5");
    drain();
    cfg_write(4'hF, 1'b1, 2'b00, 2'b01); m_byp = 0;
    settle();
    push("R5", 4, 8'h00);
    push_dif("R7");
    push("R8", 6, 8'd50);
    push("R8", 8, 8'h01);
    drain();
    cfg_write(4'hF, 1'b1, 2'b00, 2'b10);
    settle();
    push("R8", 6, 8'd125);
    drain();
    cfg_write(4'hF, 1'b1, 2'b00, 2'b11);
    settle();
    push("R8", 6, 8'd0);
    drain();
    // full reset, then new straps are captured
    rst_n = 1'b0; pwrgd = 1'b0; addr_strap = 2'b01; mode_strap = 2'b01;
    m_pwr = 0; m_oereg = 4'hF; m_byp = 1;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    settle();
    push("R5", 4, 8'h00);
    push("R9", 7, 8'h0F);
    drain();
    pwrgd = 1'b1; m_pwr = 1;
    settle();
    push("R2", 2, 8'h6C);
    push("R4", 3, 8'h01);
    push("R4", 4, 8'h01);
    push_dif("R7");
    drain();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule